// File: doc/BRIEF.md
# Camera Packet Sync Decoder

This block sits behind per-lane byte aligners of a high-speed camera serial receiver. It takes one byte per lane per word and the lane-striped bytes are put back into one sequential byte stream, lane 0 first. The stream is parsed into short and long camera packets. Frame and line boundaries come out as single-cycle pulses. RAW8 image payload comes out as one 8-bit pixel per cycle with a valid strobe.

One, two or four lanes are selected through a configuration input. Decoding starts only when every lane in use reports alignment. If any used lane loses alignment, the parser drops whatever it was in the middle of and hunts for a fresh packet header.

Top module: `csi_sync_decoder`

## Requirements
- R1: While reset is high, and in the first cycle after it, all pulse outputs and `pix_vld` are low.
- R2: `lane_cfg` selects the lane count: 0 means one lane (lane 0), 1 means two lanes (lanes 0 and 1), and 2 or 3 means four lanes. On a `lane_vld` word the bytes enter the stream in the order lane 0, lane 1, lane 2, lane 3, for the lanes in use. Words arrive at least lane-count cycles apart.
- R3: A packet begins with a 4-byte header. Byte 0 holds the data type in bits 5:0, and bits 7:6 are ignored. Bytes 1 and 2 hold a 16-bit word count, low byte first. Byte 3 is an ECC byte that is not checked.
- R4: Data type 0x00 gives one `frame_start` pulse, 0x01 gives `frame_end`, 0x02 gives `line_start` and 0x03 gives `line_end`. Each pulse lasts exactly one cycle.
- R5: For data type 0x2A (RAW8), exactly word-count payload bytes appear on `pix_data`, in stream order, with `pix_vld` high. `pix_vld` is never high on any other cycle.
- R6: The two checksum bytes after a RAW8 payload are discarded, and the byte after them is taken as the next header.
- R7: If no 0x02 packet has been seen since the last 0x00 packet (or since reset), each RAW8 header produces a `line_start` pulse. A `line_end` pulse follows in the cycle after its last pixel, or in the cycle after the header when the word count is 0.
- R8: Once a 0x02 packet has been seen, RAW8 packets produce no automatic line pulses until the next 0x00 packet.
- R9: Data types 0x10 to 0x3F other than 0x2A are skipped as long packets of word count plus two bytes. Types 0x04 to 0x0F are 4-byte packets that are ignored. Neither kind produces pulses or pixels.
- R10: No output activity occurs while any lane in use is unaligned. Align inputs of unused lanes have no effect.
- R11: Loss of alignment on a used lane abandons the current packet. All outputs are quiet in the next cycle, and the parser restarts on a header.
- R12: At most one of the four pulses and `pix_vld` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_cfg | input | 2 | Lane count select (R2) |
| lane_data | input | 32 | Byte per lane, lane n in bits 8n+7:8n |
| lane_align | input | 4 | Per-lane aligned flag |
| lane_vld | input | 1 | A word of lane bytes is present |
| frame_start | output | 1 | Frame start pulse |
| frame_end | output | 1 | Frame end pulse |
| line_start | output | 1 | Line start pulse |
| line_end | output | 1 | Line end pulse |
| pix_data | output | 8 | RAW8 pixel |
| pix_vld | output | 1 | Pixel valid |

## Verification
The bench compares the decoder's event sequence against a byte-level reference model for several kinds of stream:
- Frames with implicit line framing show whether line pulses are generated when no line-start packet has been seen.
- Frames with explicit line packets show that automatic framing is suppressed.
- Streams with skipped long packets whose payload mimics headers show whether word-count skipping is honoured.
- The same content sent over one, two and four lanes, with tight and loose word spacing, exposes lane-order and multiplexer errors.
- Alignment is dropped before a header and in the middle of a payload to show that no output appears while unaligned and that the parser resynchronises afterwards.

// File: rtl/csi_dec_pkg.sv
package csi_dec_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WC_W   = 16;
    localparam int IDX_W  = $clog2(LANES);
    localparam int CNT_W  = $clog2(LANES + 1);

    localparam logic [5:0] DT_FRAME_START = 6'h00;
    localparam logic [5:0] DT_FRAME_END   = 6'h01;
    localparam logic [5:0] DT_LINE_START  = 6'h02;
    localparam logic [5:0] DT_LINE_END    = 6'h03;
    localparam logic [5:0] DT_RAW8        = 6'h2A;
    localparam logic [5:0] DT_LONG_MIN    = 6'h10;

    typedef enum logic [1:0] {PS_HDR, PS_PAY, PS_SKIP} pstate_t;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] data;
    } sbyte_t;

    function automatic logic [LANES-1:0] cfg_mask(input logic [1:0] cfg);
        case (cfg)
            2'd0:    return LANES'(4'b0001);
            2'd1:    return LANES'(4'b0011);
            default: return '1;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] cfg_count(input logic [1:0] cfg);
        case (cfg)
            2'd0:    return CNT_W'(1);
            2'd1:    return CNT_W'(2);
            default: return CNT_W'(LANES);
        endcase
    endfunction
endpackage

// File: rtl/csi_lane_merge.sv
module csi_lane_merge
    import csi_dec_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              lane_cfg,
    input  logic [LANES*BYTE_W-1:0] lane_data,
    input  logic [LANES-1:0]        lane_align,
    input  logic                    lane_vld,
    output sbyte_t                  strm,
    output logic                    hunt
);
    logic [BYTE_W-1:0] lanes_q [LANES];
    logic [IDX_W-1:0]  sel;
    logic [CNT_W-1:0]  cnt;
    logic              load;

    always_comb begin
        hunt = ~&(lane_align | ~cfg_mask(lane_cfg));
        load = lane_vld && !hunt;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_cap
        always_ff @(posedge clk) begin
            if (load) lanes_q[g] <= lane_data[g*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hunt) begin
            cnt  <= '0;
            sel  <= '0;
            strm <= '0;
        end else begin
            strm.vld  <= (cnt != '0);
            strm.data <= lanes_q[sel];
            if (load) begin
                cnt <= cfg_count(lane_cfg);
                sel <= '0;
            end else if (cnt != '0) begin
                cnt <= cnt - CNT_W'(1);
                sel <= sel + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/csi_pkt_parser.sv
module csi_pkt_parser
    import csi_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hunt,
    input  sbyte_t            strm,
    output logic              frame_start,
    output logic              frame_end,
    output logic              line_start,
    output logic              line_end,
    output logic [BYTE_W-1:0] pix_data,
    output logic              pix_vld
);
    pstate_t           st;
    logic [1:0]        hidx;
    logic [5:0]        dt_q;
    logic [BYTE_W-1:0] wc_lo, wc_hi;
    logic [WC_W:0]     rem;
    logic              saw_ls, le_pend;
    logic [WC_W-1:0]   wc;

    always_comb wc = {wc_hi, wc_lo};

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= PS_HDR; hidx <= '0; dt_q <= '0; wc_lo <= '0; wc_hi <= '0;
            rem <= '0; saw_ls <= 1'b0; le_pend <= 1'b0;
            frame_start <= 1'b0; frame_end <= 1'b0; line_start <= 1'b0;
            line_end <= 1'b0; pix_data <= '0; pix_vld <= 1'b0;
        end else begin
            frame_start <= 1'b0; frame_end <= 1'b0; line_start <= 1'b0;
            line_end <= 1'b0; pix_vld <= 1'b0;
            if (hunt) begin
                st <= PS_HDR; hidx <= '0; le_pend <= 1'b0;
            end else begin
                line_end <= le_pend;
                le_pend  <= 1'b0;
                if (strm.vld) begin
                    unique case (st)
                        PS_HDR: begin
                            hidx <= hidx + 2'd1;
                            case (hidx)
                                2'd0: dt_q  <= strm.data[5:0];
                                2'd1: wc_lo <= strm.data;
                                2'd2: wc_hi <= strm.data;
                                default: begin
                                    if (dt_q == DT_FRAME_START) begin
                                        frame_start <= 1'b1; saw_ls <= 1'b0;
                                    end else if (dt_q == DT_FRAME_END) begin
                                        frame_end <= 1'b1;
                                    end else if (dt_q == DT_LINE_START) begin
                                        line_start <= 1'b1; saw_ls <= 1'b1;
                                    end else if (dt_q == DT_LINE_END) begin
                                        line_end <= 1'b1;
                                    end else if (dt_q == DT_RAW8) begin
                                        line_start <= !saw_ls;
                                        if (wc == '0) begin
                                            le_pend <= !saw_ls;
                                            st  <= PS_SKIP;
                                            rem <= (WC_W+1)'(2);
                                        end else begin
                                            st  <= PS_PAY;
                                            rem <= {1'b0, wc};
                                        end
                                    end else if (dt_q >= DT_LONG_MIN) begin
                                        st  <= PS_SKIP;
                                        rem <= {1'b0, wc} + (WC_W+1)'(2);
                                    end
                                end
                            endcase
                        end
                        PS_PAY: begin
                            pix_data <= strm.data;
                            pix_vld  <= 1'b1;
                            if (rem == (WC_W+1)'(1)) begin
                                le_pend <= !saw_ls;
                                st  <= PS_SKIP;
                                rem <= (WC_W+1)'(2);
                            end else begin
                                rem <= rem - (WC_W+1)'(1);
                            end
                        end
                        PS_SKIP: begin
                            rem <= rem - (WC_W+1)'(1);
                            if (rem == (WC_W+1)'(1)) st <= PS_HDR;
                        end
                        default: st <= PS_HDR;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/csi_sync_decoder.sv
module csi_sync_decoder
    import csi_dec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  lane_cfg,
    input  logic [31:0] lane_data,
    input  logic [3:0]  lane_align,
    input  logic        lane_vld,
    output logic        frame_start,
    output logic        frame_end,
    output logic        line_start,
    output logic        line_end,
    output logic [7:0]  pix_data,
    output logic        pix_vld
);
    sbyte_t strm;
    logic   hunt;

    csi_lane_merge i_merge (
        .clk(clk), .rst(rst), .lane_cfg(lane_cfg), .lane_data(lane_data),
        .lane_align(lane_align), .lane_vld(lane_vld), .strm(strm), .hunt(hunt)
    );

    csi_pkt_parser i_parser (
        .clk(clk), .rst(rst), .hunt(hunt), .strm(strm),
        .frame_start(frame_start), .frame_end(frame_end),
        .line_start(line_start), .line_end(line_end),
        .pix_data(pix_data), .pix_vld(pix_vld)
    );
endmodule

// File: rtl/csi_sync_decoder_chk.sv
module csi_sync_decoder_chk
    import csi_dec_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] lane_cfg,
    input logic [3:0] lane_align,
    input logic       frame_start,
    input logic       frame_end,
    input logic       line_start,
    input logic       line_end,
    input logic       pix_vld
);
    logic aligned;
    logic any_out;
    always_comb begin
        aligned = &(lane_align | ~cfg_mask(lane_cfg));
        any_out = frame_start | frame_end | line_start | line_end | pix_vld;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !any_out);

    assert_fs_single_R4: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);
    assert_fe_single_R4: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !frame_end);
    assert_ls_single_R7: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !line_start);
    assert_le_single_R7: assert property (@(posedge clk) disable iff (rst)
        line_end |=> !line_end);

    assert_unaligned_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !aligned |=> !any_out);

    assert_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frame_start, frame_end, line_start, line_end, pix_vld}));
endmodule

bind csi_sync_decoder csi_sync_decoder_chk i_chk (
    .clk(clk), .rst(rst), .lane_cfg(lane_cfg), .lane_align(lane_align),
    .frame_start(frame_start), .frame_end(frame_end), .line_start(line_start),
    .line_end(line_end), .pix_vld(pix_vld)
);

// File: tb/test_csi_sync_decoder.sv
module test_csi_sync_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  lane_cfg = 2'd0;
    logic [31:0] lane_data = '0;
    logic [3:0]  lane_align = 4'hF;
    logic        lane_vld = 1'b0;
    logic        frame_start, frame_end, line_start, line_end, pix_vld;
    logic [7:0]  pix_data;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    bit saw_ls = 0;
    logic [7:0] pk[$];
    int exp_q[$], got_q[$];
    logic [3:0] align_ok = 4'hF;

    always #10 clk = ~clk;

    csi_sync_decoder i_csi_sync_decoder (
        .clk(clk), .rst(rst), .lane_cfg(lane_cfg), .lane_data(lane_data),
        .lane_align(lane_align), .lane_vld(lane_vld),
        .frame_start(frame_start), .frame_end(frame_end),
        .line_start(line_start), .line_end(line_end),
        .pix_data(pix_data), .pix_vld(pix_vld)
    );

    // event codes: 0x100|pixel, 0x200 FS, 0x201 FE, 0x202 LS, 0x203 LE
    always @(negedge clk) begin
        if (!rst) begin
            if (frame_start) got_q.push_back(32'h200);
            if (frame_end)   got_q.push_back(32'h201);
            if (line_start)  got_q.push_back(32'h202);
            if (line_end)    got_q.push_back(32'h203);
            if (pix_vld)     got_q.push_back(32'h100 | int'(pix_data));
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic add_pkt(input int dt, input int wc);
        pk.push_back(8'(dt));
        pk.push_back(8'(wc));
        pk.push_back(8'(wc >> 8));
        pk.push_back(8'($urandom));
        if ((dt & 32'h3F) >= 32'h10) begin
            for (int i = 0; i < wc + 2; i++) pk.push_back(8'($urandom));
        end
    endtask

    // reference model built from the requirements
    task automatic model();
        int st = 0, idx = 0, rem = 0, dt = 0, wc = 0;
        logic [7:0] h0 = 0, h1 = 0, h2 = 0, b;
        for (int i = 0; i < pk.size(); i++) begin
            b = pk[i];
            if (st == 0) begin
                if (idx == 0) h0 = b; else if (idx == 1) h1 = b; else if (idx == 2) h2 = b;
                idx++;
                if (idx == 4) begin
                    idx = 0;
                    dt = int'(h0) & 32'h3F;
                    wc = int'({h2, h1});
                    if (dt == 0) begin exp_q.push_back(32'h200); saw_ls = 0; end
                    else if (dt == 1) exp_q.push_back(32'h201);
                    else if (dt == 2) begin exp_q.push_back(32'h202); saw_ls = 1; end
                    else if (dt == 3) exp_q.push_back(32'h203);
                    else if (dt == 32'h2A) begin
                        if (!saw_ls) exp_q.push_back(32'h202);
                        if (wc == 0) begin
                            if (!saw_ls) exp_q.push_back(32'h203);
                            st = 2; rem = 2;
                        end else begin st = 1; rem = wc; end
                    end else if (dt >= 32'h10) begin st = 2; rem = wc + 2; end
                end
            end else if (st == 1) begin
                exp_q.push_back(32'h100 | int'(b));
                rem--;
                if (rem == 0) begin
                    if (!saw_ls) exp_q.push_back(32'h203);
                    st = 2; rem = 2;
                end
            end else begin
                rem--;
                if (rem == 0) st = 0;
            end
        end
    endtask

    task automatic feed(input int n);
        int nw;
        while (pk.size() % n != 0) pk.push_back(8'h00);
        nw = pk.size() / n;
        @(negedge clk);
        for (int w = 0; w < nw; w++) begin
            lane_data = '0;
            for (int g = 0; g < n; g++) lane_data[g*8 +: 8] = pk[w*n + g];
            lane_vld = 1'b1;
            @(negedge clk);
            lane_vld = 1'b0;
            repeat (n - 1 + (($urandom % 4) == 0 ? 1 : 0)) @(negedge clk);
        end
    endtask

    function automatic int lanes_of(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction

    task automatic hunt_pulse();
        @(negedge clk) lane_align = 4'h0;
        @(negedge clk) lane_align = align_ok;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_scn(input string req);
        int n, bad;
        n = lanes_of(lane_cfg);
        while (pk.size() % n != 0) pk.push_back(8'h00);
        exp_q.delete(); got_q.delete();
        model();
        feed(n);
        repeat (12) @(negedge clk);
        hunt_pulse();
        bad = -1;
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            if (bad < 0 && got_q[i] != exp_q[i]) bad = i;
        if (got_q.size() != exp_q.size())
            chk(0, {req, " event count"}, got_q.size(), exp_q.size());
        else if (bad >= 0)
            chk(0, {req, " event value"}, got_q[bad], exp_q[bad]);
        else
            chk(1, req, 0, 0);
        pk.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk({frame_start, frame_end, line_start, line_end, pix_vld} == 5'b0,
            "R1 reset outputs", {frame_start, frame_end, line_start, line_end, pix_vld}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({frame_start, frame_end, line_start, line_end, pix_vld} == 5'b0,
            "R1 after reset", {frame_start, frame_end, line_start, line_end, pix_vld}, 0);

        // R3 R4 R5 R6 R7: one lane, implicit line framing
        lane_cfg = 2'd0; align_ok = 4'b0001; lane_align = align_ok;
        add_pkt(0, 16'h1234); add_pkt(32'h2A, 4); add_pkt(32'h2A, 1); add_pkt(1, 0);
        run_scn("R7 one lane implicit lines");

        // R2 R8 R10: two lanes, unused lanes unaligned, explicit lines
        lane_cfg = 2'd1; align_ok = 4'b0011; lane_align = align_ok;
        add_pkt(0, 0); add_pkt(2, 0); add_pkt(32'h2A, 3); add_pkt(3, 0);
        add_pkt(32'h2A, 2); add_pkt(1, 0);
        run_scn("R8 two lanes explicit lines");

        // R9: four lanes, skipped long packet with header-like payload, VC bits, short unknown
        lane_cfg = 2'd2; align_ok = 4'hF; lane_align = align_ok;
        add_pkt(32'hC0, 0);
        pk.push_back(8'h12); pk.push_back(8'd6); pk.push_back(8'd0); pk.push_back(8'h55);
        for (int i = 0; i < 8; i++) pk.push_back((i % 4 == 0) ? 8'h00 : 8'h01);
        add_pkt(32'h08, 16'hFFFF); add_pkt(32'h6A, 0); add_pkt(32'hEA, 2); add_pkt(1, 0);
        run_scn("R9 skip and ignore");

        // R10: decoding held off while a used lane is unaligned
        lane_cfg = 2'd3; align_ok = 4'hF; lane_align = 4'b0111;
        exp_q.delete(); got_q.delete();
        add_pkt(0, 0); add_pkt(1, 0);
        feed(4);
        repeat (10) @(negedge clk);
        chk(got_q.size() == 0, "R10 unaligned lane blocks decode", got_q.size(), 0);
        pk.delete();
        lane_align = align_ok;
        repeat (2) @(negedge clk);

        // R11: alignment lost mid payload, then clean recovery
        lane_cfg = 2'd0; align_ok = 4'b0001; lane_align = align_ok;
        add_pkt(0, 0);
        pk.push_back(8'h2A); pk.push_back(8'd9); pk.push_back(8'd0); pk.push_back(8'h00);
        pk.push_back(8'hA1); pk.push_back(8'hA2); pk.push_back(8'hA3);
        run_scn("R11 partial packet dropped");
        add_pkt(1, 0); add_pkt(32'h2A, 2);
        run_scn("R11 resync after alignment loss");

        // R6 R12: zero-length RAW8 on four lanes with tight spacing
        lane_cfg = 2'd2; align_ok = 4'hF; lane_align = align_ok;
        add_pkt(0, 0); add_pkt(32'h2A, 0); add_pkt(32'h2A, 5); add_pkt(1, 0);
        run_scn("R6 zero length and checksum skip");

        // random frames across lane counts
        for (int t = 0; t < 30; t++) begin
            int lines;
            lane_cfg = 2'($urandom % 4);
            align_ok = cfg_unused_rand(lane_cfg);
            lane_align = align_ok;
            add_pkt((($urandom % 2) != 0) ? 32'h40 : 0, $urandom % 65536);
            lines = 1 + int'($urandom % 4);
            for (int l = 0; l < lines; l++) begin
                case ($urandom % 4)
                    0: add_pkt(32'h2A, $urandom % 7);
                    1: begin add_pkt(2, 0); add_pkt(32'h2A, 1 + $urandom % 6); add_pkt(3, 0); end
                    2: add_pkt(((($urandom % 2) != 0) ? 32'h12 : 32'h2B), $urandom % 6);
                    default: add_pkt(4 + int'($urandom % 12), $urandom % 65536);
                endcase
            end
            add_pkt(1, 0);
            run_scn("R5 random frame");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    function automatic logic [3:0] cfg_unused_rand(input logic [1:0] c);
        logic [3:0] r;
        r = 4'($urandom);
        return (c == 2'd0) ? (r | 4'b0001) : (c == 2'd1) ? (r | 4'b0011) : 4'hF;
    endfunction
endmodule